// File: doc/BRIEF.md
# Direct-Mapped Line Cache Read Path with Burst Return

This block is the read side of a direct-mapped second-level cache. The CPU presents a physical address with a valid strobe. The block splits the address into an ignored byte offset, a line index and a tag. It then looks up a per-line tag and valid bit. On a hit the selected 256-bit line comes back over a 64-bit bus as four beats. The first beat is four cycles after the request is taken and each later beat follows one cycle after the one before it, which is the 4-1-1-1 pattern.

On a miss the block pulses a miss strobe and waits for the memory side to offer a whole 256-bit line on the fill port. If the address lies inside the cacheable window, that line is written into the data store along with its tag and valid bit. The burst is then replayed from the filled line with the same timing. The width of the tag alone sets the cacheable window. An address with any bit set above the tag field is served through the same miss and fill sequence but is never allocated. By default the store holds 1024 lines (32 KB) and the window is 8 MB. Setting the index width to 13 gives 256 KB of store and a 64 MB window.

Top module: `crp_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rd_valid`, `rd_last` and `miss` are 0, and every line is invalid, so the first access to any line misses.
- R2: A request taken at clock edge N that hits gives beats after edges N+4, N+5, N+6 and N+7, with `rd_valid` high on all four and `rd_last` high only on the fourth.
- R3: Beats carry the line in ascending order: line bits [63:0] first, then [127:64], then [191:128], then [255:192].
- R4: A hit needs the line's valid bit set and a stored tag equal to address bits [22:15]. The line index is address bits [14:5]. A different tag at the same index misses.
- R5: On a miss, `miss` is high for exactly the one cycle after edge N+4. No beat appears until a fill is taken.
- R6: A fill taken at edge F while waiting gives the burst after edges F+4 to F+7 from the filled data. A cacheable filled line then hits on the next access.
- R7: An address with any bit of [31:23] set always misses and is never written into the store, so it neither hits later nor disturbs the line already held at its index.
- R8: `req_ready` is low from the edge that takes a request until the cycle after the last beat. `req_valid` while `req_ready` is low has no effect.
- R9: `fill_valid` while no miss is waiting has no effect on the stored lines.
- R10: Address bits [4:0] do not affect lookup or beat order.
- R11: Filling a new tag at an index replaces the line held there, and the replaced tag then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | 32 | Physical byte address |
| req_ready | output | 1 | High when a request can be taken |
| rd_data | output | 64 | Burst beat data |
| rd_valid | output | 1 | Beat valid |
| rd_last | output | 1 | Marks the fourth beat |
| miss | output | 1 | One-cycle miss strobe |
| fill_valid | input | 1 | Memory side offers a line |
| fill_data | input | 256 | Whole line from memory |

## Verification
The bench times every beat against the cycle in which the request or fill was taken. A design with an extra or missing pipeline stage therefore shows up as a beat on the wrong cycle, and a reversed or rotated word order shows up as a data mismatch. It sends aliasing tags to one index to catch a design that compares too few tag bits or skips the valid bit, and it shows that eviction replaces the old line. It sends an uncacheable address that matches the tag of a resident line: a design that allocates it or ignores the high bits would return stale data, hit on the second access, or corrupt the resident line. It also pokes requests during a burst and fills while idle, and it checks that neither produces beats or changes the stored data.

// File: rtl/crp_pkg.sv
package crp_pkg;
    localparam int OFF_W     = 5;
    localparam int BEAT_W    = 64;
    localparam int BEATS     = 4;
    localparam int LINE_W    = BEAT_W * BEATS;
    localparam int FIRST_LAT = 4;
    localparam int CNT_W     = $clog2(FIRST_LAT);
    localparam int BEAT_IW   = $clog2(BEATS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_MISS,
        ST_BURST,
        ST_TAIL
    } ctrl_state_e;
endpackage

// File: rtl/crp_addr_split.sv
module crp_addr_split
    import crp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic              cacheable_o
);
    localparam int TAG_LO = OFF_W + IDX_W;
    localparam int TOP_LO = TAG_LO + TAG_W;

    logic unused_off;
    assign unused_off = ^addr_i[OFF_W-1:0];

    assign idx_o = addr_i[OFF_W +: IDX_W];
    assign tag_o = addr_i[TAG_LO +: TAG_W];

    generate
        if (ADDR_W > TOP_LO) begin : g_upper
            assign cacheable_o = (addr_i[ADDR_W-1:TOP_LO] == '0);
        end else begin : g_full
            assign cacheable_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/crp_tag_store.sv
module crp_tag_store #(
    parameter int IDX_W = 10,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx_i,
    input  logic [TAG_W-1:0] look_tag_i,
    output logic             hit_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [TAG_W-1:0] wr_tag_i
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en_i) begin
            valid_q[wr_idx_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            tag_q[wr_idx_i] <= wr_tag_i;
        end
    end

    assign hit_o = valid_q[look_idx_i] && (tag_q[look_idx_i] == look_tag_i);
endmodule

// File: rtl/crp_line_store.sv
module crp_line_store
    import crp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [LINE_W-1:0] wr_line_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [LINE_W-1:0] rd_line_o
);
    localparam int LINES = 1 << IDX_W;

    logic [LINE_W-1:0] mem_q [LINES];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_line_i;
        end
    end

    assign rd_line_o = mem_q[rd_idx_i];
endmodule

// File: rtl/crp_burst_ctrl.sv
module crp_burst_ctrl
    import crp_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int TAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [IDX_W-1:0]  req_idx_i,
    input  logic [TAG_W-1:0]  req_tag_i,
    input  logic              req_cacheable_i,
    output logic              req_ready_o,
    output logic [IDX_W-1:0]  look_idx_o,
    output logic [TAG_W-1:0]  look_tag_o,
    input  logic              hit_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              fill_valid_i,
    input  logic [LINE_W-1:0] fill_data_i,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [TAG_W-1:0]  wr_tag_o,
    output logic [LINE_W-1:0] wr_line_o,
    output logic [BEAT_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              rd_last_o,
    output logic              miss_o
);
    typedef struct packed {
        ctrl_state_e        state;
        logic [CNT_W-1:0]   cnt;
        logic               replay;
        logic [IDX_W-1:0]   idx;
        logic [TAG_W-1:0]   tag;
        logic               cacheable;
        logic [LINE_W-1:0]  line;
        logic [BEAT_IW-1:0] beat;
        logic [BEAT_W-1:0]  out_data;
        logic               out_valid;
        logic               out_last;
        logic               miss;
    } ctrl_t;

    localparam logic [CNT_W-1:0]   LAST_WAIT = CNT_W'(FIRST_LAT - 1);
    localparam logic [BEAT_IW-1:0] LAST_BEAT = BEAT_IW'(BEATS - 1);

    ctrl_t q, d;
    logic  wr_en;

    always_comb begin
        d           = q;
        d.out_valid = 1'b0;
        d.out_last  = 1'b0;
        d.miss      = 1'b0;
        wr_en       = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.state     = ST_WAIT;
                    d.idx       = req_idx_i;
                    d.tag       = req_tag_i;
                    d.cacheable = req_cacheable_i;
                    d.cnt       = '0;
                    d.replay    = 1'b0;
                end
            end
            ST_WAIT: begin
                if (q.cnt != LAST_WAIT) begin
                    d.cnt = q.cnt + 1'b1;
                end else if (q.replay) begin
                    d.state     = ST_BURST;
                    d.out_data  = q.line[0 +: BEAT_W];
                    d.out_valid = 1'b1;
                    d.beat      = BEAT_IW'(1);
                end else if (hit_i && q.cacheable) begin
                    d.state     = ST_BURST;
                    d.line      = line_i;
                    d.out_data  = line_i[0 +: BEAT_W];
                    d.out_valid = 1'b1;
                    d.beat      = BEAT_IW'(1);
                end else begin
                    d.state = ST_MISS;
                    d.miss  = 1'b1;
                end
            end
            ST_MISS: begin
                if (fill_valid_i) begin
                    wr_en    = q.cacheable;
                    d.line   = fill_data_i;
                    d.replay = 1'b1;
                    d.cnt    = '0;
                    d.state  = ST_WAIT;
                end
            end
            ST_BURST: begin
                d.out_data  = q.line[{q.beat, 6'd0} +: BEAT_W];
                d.out_valid = 1'b1;
                d.out_last  = (q.beat == LAST_BEAT);
                d.beat      = q.beat + 1'b1;
                if (q.beat == LAST_BEAT) begin
                    d.state = ST_TAIL;
                end
            end
            ST_TAIL: begin
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state     <= ST_IDLE;
            q.cnt       <= '0;
            q.replay    <= 1'b0;
            q.idx       <= '0;
            q.tag       <= '0;
            q.cacheable <= 1'b0;
            q.line      <= '0;
            q.beat      <= '0;
            q.out_data  <= '0;
            q.out_valid <= 1'b0;
            q.out_last  <= 1'b0;
            q.miss      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign req_ready_o = (q.state == ST_IDLE);
    assign look_idx_o  = q.idx;
    assign look_tag_o  = q.tag;
    assign wr_en_o     = wr_en;
    assign wr_idx_o    = q.idx;
    assign wr_tag_o    = q.tag;
    assign wr_line_o   = fill_data_i;
    assign rd_data_o   = q.out_data;
    assign rd_valid_o  = q.out_valid;
    assign rd_last_o   = q.out_last;
    assign miss_o      = q.miss;
endmodule

// File: rtl/crp_top.sv
module crp_top
    import crp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [BEAT_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_last,
    output logic              miss,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_data
);
    logic [IDX_W-1:0]  req_idx, look_idx, wr_idx;
    logic [TAG_W-1:0]  req_tag, look_tag, wr_tag;
    logic              req_cacheable, hit, wr_en;
    logic [LINE_W-1:0] rd_line, wr_line;

    crp_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split (
        .addr_i      (req_addr),
        .idx_o       (req_idx),
        .tag_o       (req_tag),
        .cacheable_o (req_cacheable)
    );

    crp_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_idx_i (look_idx),
        .look_tag_i (look_tag),
        .hit_o      (hit),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_tag_i   (wr_tag)
    );

    crp_line_store #(.IDX_W(IDX_W)) u_lines (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_line_i (wr_line),
        .rd_idx_i  (look_idx),
        .rd_line_o (rd_line)
    );

    crp_burst_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid_i     (req_valid),
        .req_idx_i       (req_idx),
        .req_tag_i       (req_tag),
        .req_cacheable_i (req_cacheable),
        .req_ready_o     (req_ready),
        .look_idx_o      (look_idx),
        .look_tag_o      (look_tag),
        .hit_i           (hit),
        .line_i          (rd_line),
        .fill_valid_i    (fill_valid),
        .fill_data_i     (fill_data),
        .wr_en_o         (wr_en),
        .wr_idx_o        (wr_idx),
        .wr_tag_o        (wr_tag),
        .wr_line_o       (wr_line),
        .rd_data_o       (rd_data),
        .rd_valid_o      (rd_valid),
        .rd_last_o       (rd_last),
        .miss_o          (miss)
    );
endmodule

// File: rtl/crp_checker.sv
module crp_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rd_valid,
    input logic rd_last,
    input logic miss
);
    logic [2:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else if (rd_valid) run_q <= run_q + 3'd1;
        else run_q <= '0;
    end

    AST_LAST_IS_FOURTH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> (rd_valid && run_q == 3'd3)); // R2
    AST_BEATS_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_last) |=> rd_valid); // R2
    AST_MISS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> !miss); // R5
    AST_MISS_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> !rd_valid); // R5
    AST_BUSY_DURING_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !req_ready); // R8
    AST_TAKE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |=> (req_ready && !rd_valid)); // R8
endmodule

bind crp_top crp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .rd_last   (rd_last),
    .miss      (miss)
);

// File: tb/sim_crp_top.sv
module sim_crp_top;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         req_ready, rd_valid, rd_last, miss;
    logic [63:0]  rd_data;
    logic         fill_valid = 1'b0;
    logic [255:0] fill_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crp_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_last(rd_last), .miss(miss), .fill_valid(fill_valid), .fill_data(fill_data)
    );

    typedef struct {
        logic [63:0] data;
        logic        last;
        int          cyc;
        string       rq;
    } beat_t;

    beat_t exp_q[$];
    int    cyc = 0;
    int    n_checks = 0;
    int    n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a beat shows up
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected beat", rd_data, 64'd0);
            end else begin
                beat_t e;
                e = exp_q.pop_front();
                check(rd_data == e.data, e.rq, "beat data", rd_data, e.data);
                check(rd_last == e.last, e.rq, "last flag", 64'(rd_last), 64'(e.last));
                check(cyc == e.cyc, e.rq, "beat cycle", 64'(cyc), 64'(e.cyc));
            end
        end
    end

    function automatic logic [255:0] mk_line(input int s);
        logic [255:0] l;
        for (int w = 0; w < 4; w++) l[w*64 +: 64] = {32'(s), 32'hA5000000 | 32'(w)};
        return l;
    endfunction

    function automatic logic [31:0] mk_addr(input int up, input int tag,
                                            input int idx, input int off);
        return (32'(up) << 23) | (32'(tag & 8'hFF) << 15) | (32'(idx & 10'h3FF) << 5)
               | 32'(off & 5'h1F);
    endfunction

    task automatic push_burst(input logic [255:0] l, input int base, input string rq);
        for (int w = 0; w < 4; w++) begin
            beat_t b;
            b.data = l[w*64 +: 64];
            b.last = (w == 3);
            b.cyc  = base + 4 + w;
            b.rq   = rq;
            exp_q.push_back(b);
        end
    endtask

    // Driver: issues one read, pushes the beats it should produce
    task automatic rd(input logic [31:0] a, input bit exp_hit, input logic [255:0] l,
                      input string rq, input bit poke);
        int c, f;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        c = cyc;
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R8", "ready after take", 64'(req_ready), 64'd0);
        if (poke) begin
            req_valid = 1'b1;
            req_addr  = a ^ 32'h0000_8000;
        end
        if (exp_hit) begin
            push_burst(l, c, rq);
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end else begin
            repeat (4) @(negedge clk);
            req_valid = 1'b0;
            check(miss == 1'b1, "R5", "miss strobe", 64'(miss), 64'd1);
            @(negedge clk);
            check(miss == 1'b0, "R5", "miss width", 64'(miss), 64'd0);
            @(negedge clk);
            fill_valid = 1'b1;
            fill_data  = l;
            @(negedge clk);
            f = cyc;
            fill_valid = 1'b0;
            fill_data  = '0;
            push_burst(l, f, rq);
        end
        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
        check(rd_valid == 1'b0, "R8", "idle after burst", 64'(rd_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] a_a, a_b, a_u, a_c;
        logic [255:0] l1, l2, lu, l3;
        a_a = mk_addr(0, 8'h11, 5, 0);
        a_b = mk_addr(0, 8'h22, 5, 0);
        a_u = mk_addr(1, 8'h11, 5, 0);
        a_c = mk_addr(0, 8'hFF, 1023, 0);
        l1 = mk_line(1); l2 = mk_line(2); lu = mk_line(99); l3 = mk_line(3);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
        check(rd_valid == 1'b0, "R1", "reset valid", 64'(rd_valid), 64'd0);
        check(rd_last == 1'b0, "R1", "reset last", 64'(rd_last), 64'd0);
        check(miss == 1'b0, "R1", "reset miss", 64'(miss), 64'd0);

        rd(a_a, 1'b0, l1, "R1", 1'b0);                      // cold miss, fill R6
        rd(mk_addr(0, 8'h11, 5, 17), 1'b1, l1, "R10", 1'b0); // offset ignored
        rd(a_a, 1'b1, l1, "R2", 1'b1);                      // hit timing, poke R8
        rd(a_b, 1'b0, l2, "R4", 1'b0);                      // alias tag misses
        rd(a_b, 1'b1, l2, "R6", 1'b0);                      // filled line hits
        rd(a_a, 1'b0, l1, "R11", 1'b0);                     // evicted tag misses
        rd(a_u, 1'b0, lu, "R7", 1'b0);                      // uncacheable
        rd(a_u, 1'b0, lu, "R7", 1'b0);                      // still misses
        rd(a_a, 1'b1, l1, "R7", 1'b0);                      // resident line intact

        @(negedge clk);
        fill_valid = 1'b1;
        fill_data  = lu;
        repeat (2) @(negedge clk);
        fill_valid = 1'b0;
        check(rd_valid == 1'b0, "R9", "stray fill beat", 64'(rd_valid), 64'd0);
        rd(a_a, 1'b1, l1, "R9", 1'b0);                      // stray fill ignored

        rd(a_c, 1'b0, l3, "R3", 1'b0);                      // top index, top tag
        rd(a_c, 1'b1, l3, "R3", 1'b0);

        repeat (5) @(negedge clk);
        check(req_ready == 1'b1, "R8", "ready idle", 64'(req_ready), 64'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule